// File: doc/BRIEF.md
# Command/Acknowledge Register Bridge

This block opens a small window in a host's 32-bit register bus. Through that window the host reaches a second, private 32-bit register space inside a management controller. The host never addresses the private space directly. It loads a target address, and write data when it is writing. It then sets a read or write bit in a command word and polls that word until the bridge raises an acknowledge flag. Once it has seen the acknowledge, the host writes zero to the command word and reads it back as zero before it starts the next access.

Behind the window, the bridge issues a one-cycle request to a backing register file and waits for that file's response. The file may hold off its response for any number of cycles. It holds a hardware build identifier, a firmware identifier, a pair of MAC address words (the upper word also carries a count of consecutive addresses) and a bank of scratch words. The bridge checks each target address before it issues a request. A target that is misaligned or beyond the private space still completes, but it never reaches the register file.

Top module: `mbox_bridge`

## Requirements
- R1: After reset, all four window words read as zero.
- R2: The window is decoded only at host byte addresses 0x400 (command), 0x404 (target address), 0x408 (returned data) and 0x40C (outgoing data), with the two low address bits zero. A host read anywhere else returns zero, and a host write anywhere else changes nothing.
- R3: Writing 0x2 (bit 1, write request) to the idle command word stores the outgoing data at the target address. The bridge then sets bit 2 (acknowledge), so the command word reads 0x6.
- R4: Writing 0x1 (bit 0, read request) to the idle command word fetches the target register. The fetched value is in the returned-data word no later than the cycle in which acknowledge appears, and the command word then reads 0x5.
- R5: Once acknowledge is set, a host write to the command word with bits 1:0 both zero clears the whole command word, acknowledge included. Bit 2 of any host write is ignored, so the host can never set acknowledge.
- R6: While a request is in flight or acknowledged and not yet cleared, further read or write requests are ignored. While a request is in flight, a clear is ignored too, and the command word keeps its value.
- R7: A command write with bits 0 and 1 both set does nothing. The command word stays zero, no request is issued and acknowledge never appears.
- R8: A target address above 0xFFF, or one that is not a multiple of 4, still completes with acknowledge. A read of such an address returns zero, and a write to it changes no register.
- R9: Each accepted in-range command produces exactly one single-cycle request to the register file. Acknowledge stays low until the response arrives, however long the file stalls.
- R10: The register file returns the build identifier at 0x000 and the firmware identifier at 0x004, and host writes to either are dropped. The MAC low word at 0x020, the MAC high word at 0x024 (count in bits 23:16) and the scratch words from 0x100 upward are writable. Every other location reads as zero.
- R11: The returned-data word is read-only to the host.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_sel | input | 1 | Host access strobe for this cycle |
| hst_wr | input | 1 | Host access is a write when high |
| hst_addr | input | HA_W | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid in the same cycle as the strobe |
| bk_stall | input | 1 | Holds off the register file's response while high |

## Verification
The hardest situation to reach is a host command that arrives while an earlier request is still in flight. From the ports, the window for that is normally only one or two cycles wide. The bench holds the register file's stall input high so that a read stays pending. While it is pending, the bench writes a new request and a clear, and it confirms that the command word still shows the pending read without acknowledge. It then releases the stall and checks the value that comes back. Misaligned and out-of-space targets are chosen so that they would alias onto a scratch word if the range check were missing. A follow-up read of that scratch word shows whether the write slipped through.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int DW   = 32;
    localparam int IA_W = 12;
    localparam int IX_W = IA_W - 2;

    localparam logic [1:0] OFS_CMD  = 2'd0;
    localparam logic [1:0] OFS_ADDR = 2'd1;
    localparam logic [1:0] OFS_RDAT = 2'd2;
    localparam logic [1:0] OFS_WDAT = 2'd3;

    localparam int B_RD  = 0;
    localparam int B_WR  = 1;
    localparam int B_ACK = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } st_e;

    typedef struct packed {
        st_e           st;
        logic [2:0]    cmd;
        logic [DW-1:0] addr;
        logic [DW-1:0] rdat;
        logic [DW-1:0] wdat;
    } ctl_s;
endpackage

// File: rtl/mbox_range_chk.sv
module mbox_range_chk #(
    parameter logic [31:0] TOP_ADDR = 32'h0000_0FFF
) (
    input  logic [31:0] addr,
    output logic        ok
);
    // legal: inside the private space and word aligned
    assign ok = (addr <= TOP_ADDR) && (addr[1:0] == 2'b00);
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
#(
    parameter int              HA_W     = 12,
    parameter logic [HA_W-1:0] WIN_BASE = 12'h400
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hst_sel,
    input  logic            hst_wr,
    input  logic [HA_W-1:0] hst_addr,
    input  logic [DW-1:0]   hst_wdata,
    output logic [DW-1:0]   hst_rdata,
    output logic [DW-1:0]   addr_o,
    input  logic            addr_ok_i,
    output logic            bk_req_o,
    output logic            bk_we_o,
    output logic [IX_W-1:0] bk_idx_o,
    output logic [DW-1:0]   bk_wdata_o,
    input  logic            bk_rsp_vld_i,
    input  logic [DW-1:0]   bk_rsp_data_i,
    output logic [2:0]      cmd_o
);
    localparam int              TAG_W   = HA_W - 4;
    localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[HA_W-1:4];

    ctl_s q, d;
    logic       win_hit;
    logic [1:0] fld;

    assign win_hit = hst_sel && (hst_addr[HA_W-1:4] == WIN_TAG) && (hst_addr[1:0] == 2'b00);
    assign fld     = hst_addr[3:2];

    always_comb begin
        d        = q;
        bk_req_o = 1'b0;

        // host writes; command accepted only when the sequencer is at rest
        if (win_hit && hst_wr) begin
            unique case (fld)
                OFS_CMD: begin
                    if (hst_wdata[1:0] == 2'b00) begin
                        if (q.st == ST_IDLE || q.st == ST_DONE) begin
                            d.cmd = 3'b000;
                            d.st  = ST_IDLE;
                        end
                    end else if (hst_wdata[1:0] != 2'b11 && q.st == ST_IDLE) begin
                        d.cmd = {1'b0, hst_wdata[1:0]};
                        d.st  = ST_ISSUE;
                    end
                end
                OFS_ADDR: d.addr = hst_wdata;
                OFS_WDAT: d.wdat = hst_wdata;
                default:  ;
            endcase
        end

        // sequencer
        unique case (q.st)
            ST_ISSUE: begin
                if (addr_ok_i) begin
                    bk_req_o = 1'b1;
                    d.st     = ST_WAIT;
                end else begin
                    if (q.cmd[B_RD]) d.rdat = '0;
                    d.cmd[B_ACK] = 1'b1;
                    d.st         = ST_DONE;
                end
            end
            ST_WAIT: begin
                if (bk_rsp_vld_i) begin
                    if (q.cmd[B_RD]) d.rdat = bk_rsp_data_i;
                    d.cmd[B_ACK] = 1'b1;
                    d.st         = ST_DONE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        hst_rdata = '0;
        if (win_hit && !hst_wr) begin
            unique case (fld)
                OFS_CMD:  hst_rdata = {{(DW-3){1'b0}}, q.cmd};
                OFS_ADDR: hst_rdata = q.addr;
                OFS_RDAT: hst_rdata = q.rdat;
                default:  hst_rdata = q.wdat;
            endcase
        end
    end

    assign addr_o     = q.addr;
    assign bk_we_o    = q.cmd[B_WR];
    assign bk_idx_o   = q.addr[IA_W-1:2];
    assign bk_wdata_o = q.wdat;
    assign cmd_o      = q.cmd;
endmodule

// File: rtl/mbox_regfile.sv
module mbox_regfile
    import mbox_pkg::*;
#(
    parameter logic [DW-1:0]   BUILD_ID   = 32'h0002_0100,
    parameter logic [DW-1:0]   FW_ID      = 32'h0001_0203,
    parameter logic [DW-1:0]   MAC_LO_RST = 32'h001B_2C3D,
    parameter logic [DW-1:0]   MAC_HI_RST = 32'h0008_4E5F,
    parameter logic [IA_W-1:0] SCR_BASE   = 12'h100,
    parameter int              SCR_N      = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic            we_i,
    input  logic [IX_W-1:0] idx_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic            stall_i,
    output logic            rsp_vld_o,
    output logic [DW-1:0]   rsp_data_o
);
    localparam logic [IX_W-1:0] IX_BUILD = IX_W'(0);
    localparam logic [IX_W-1:0] IX_FW    = IX_W'(1);
    localparam logic [IX_W-1:0] IX_MLO   = IX_W'(8);
    localparam logic [IX_W-1:0] IX_MHI   = IX_W'(9);
    localparam logic [IX_W-1:0] SCR_IX   = SCR_BASE[IA_W-1:2];

    typedef struct packed {
        logic                      busy;
        logic                      we;
        logic [IX_W-1:0]           idx;
        logic [DW-1:0]             wd;
        logic [DW-1:0]             mlo;
        logic [DW-1:0]             mhi;
        logic [SCR_N-1:0][DW-1:0]  scr;
    } rf_s;

    rf_s q, d;
    logic [SCR_N-1:0] scr_hit;

    for (genvar g = 0; g < SCR_N; g++) begin : g_scr
        assign scr_hit[g] = (q.idx == SCR_IX + IX_W'(g));
    end

    assign rsp_vld_o = q.busy && !stall_i;

    always_comb begin
        d = q;
        if (req_i) begin
            d.busy = 1'b1;
            d.we   = we_i;
            d.idx  = idx_i;
            d.wd   = wdata_i;
        end
        if (rsp_vld_o) begin
            d.busy = 1'b0;
            if (q.we) begin
                if (q.idx == IX_MLO) d.mlo = q.wd;
                if (q.idx == IX_MHI) d.mhi = q.wd;
                for (int i = 0; i < SCR_N; i++)
                    if (scr_hit[i]) d.scr[i] = q.wd;
            end
        end
    end

    always_comb begin
        rsp_data_o = '0;
        unique case (q.idx)
            IX_BUILD: rsp_data_o = BUILD_ID;
            IX_FW:    rsp_data_o = FW_ID;
            IX_MLO:   rsp_data_o = q.mlo;
            IX_MHI:   rsp_data_o = q.mhi;
            default:  ;
        endcase
        for (int i = 0; i < SCR_N; i++)
            if (scr_hit[i]) rsp_data_o = q.scr[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.mlo  <= MAC_LO_RST;
            q.mhi  <= MAC_HI_RST;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
    import mbox_pkg::*;
#(
    parameter int              HA_W       = 12,
    parameter logic [HA_W-1:0] WIN_BASE   = 12'h400,
    parameter logic [DW-1:0]   BUILD_ID   = 32'h0002_0100,
    parameter logic [DW-1:0]   FW_ID      = 32'h0001_0203,
    parameter logic [DW-1:0]   MAC_LO_RST = 32'h001B_2C3D,
    parameter logic [DW-1:0]   MAC_HI_RST = 32'h0008_4E5F,
    parameter logic [IA_W-1:0] SCR_BASE   = 12'h100,
    parameter int              SCR_N      = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hst_sel,
    input  logic            hst_wr,
    input  logic [HA_W-1:0] hst_addr,
    input  logic [31:0]     hst_wdata,
    output logic [31:0]     hst_rdata,
    input  logic            bk_stall
);
    localparam logic [31:0] SPACE_TOP = 32'((1 << IA_W) - 1);

    logic [DW-1:0]   tgt_addr;
    logic            tgt_ok;
    logic            bk_req;
    logic            bk_we;
    logic [IX_W-1:0] bk_idx;
    logic [DW-1:0]   bk_wdata;
    logic            bk_rsp_vld;
    logic [DW-1:0]   bk_rsp_data;
    logic [2:0]      cmd_view;

    mbox_ctrl #(.HA_W(HA_W), .WIN_BASE(WIN_BASE)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .hst_sel      (hst_sel),
        .hst_wr       (hst_wr),
        .hst_addr     (hst_addr),
        .hst_wdata    (hst_wdata),
        .hst_rdata    (hst_rdata),
        .addr_o       (tgt_addr),
        .addr_ok_i    (tgt_ok),
        .bk_req_o     (bk_req),
        .bk_we_o      (bk_we),
        .bk_idx_o     (bk_idx),
        .bk_wdata_o   (bk_wdata),
        .bk_rsp_vld_i (bk_rsp_vld),
        .bk_rsp_data_i(bk_rsp_data),
        .cmd_o        (cmd_view)
    );

    mbox_range_chk #(.TOP_ADDR(SPACE_TOP)) rng_i (
        .addr(tgt_addr),
        .ok  (tgt_ok)
    );

    mbox_regfile #(
        .BUILD_ID  (BUILD_ID),
        .FW_ID     (FW_ID),
        .MAC_LO_RST(MAC_LO_RST),
        .MAC_HI_RST(MAC_HI_RST),
        .SCR_BASE  (SCR_BASE),
        .SCR_N     (SCR_N)
    ) rf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (bk_req),
        .we_i      (bk_we),
        .idx_i     (bk_idx),
        .wdata_i   (bk_wdata),
        .stall_i   (bk_stall),
        .rsp_vld_o (bk_rsp_vld),
        .rsp_data_o(bk_rsp_data)
    );
endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk #(
    parameter int              HA_W     = 12,
    parameter logic [HA_W-1:0] WIN_BASE = 12'h400
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hst_sel,
    input logic            hst_wr,
    input logic [HA_W-1:0] hst_addr,
    input logic [1:0]      hst_wd_lo,
    input logic            req,
    input logic            rsp,
    input logic [2:0]      cmd
);
    logic outst_q;
    logic clr_wr;

    assign clr_wr = hst_sel && hst_wr && (hst_addr == WIN_BASE) && (hst_wd_lo == 2'b00);

    always_ff @(posedge clk) begin
        if (!rst_n)   outst_q <= 1'b0;
        else if (req) outst_q <= 1'b1;
        else if (rsp) outst_q <= 1'b0;
    end

    // R9: the request lasts a single cycle
    a_r9_req_single: assert property (@(posedge clk) disable iff (!rst_n) req |=> !req);
    // R9: no acknowledge while the register file still owes a response
    a_r9_no_ack_outstanding: assert property (@(posedge clk) disable iff (!rst_n) outst_q |-> !cmd[2]);
    // R9: responses only arrive for an issued request
    a_r9_rsp_expected: assert property (@(posedge clk) disable iff (!rst_n) rsp |-> outst_q);
    // R7: both request bits never held together
    a_r7_no_dual: assert property (@(posedge clk) disable iff (!rst_n) !(cmd[0] && cmd[1]));
    // R6: acknowledge survives everything but a clear
    a_r6_ack_holds: assert property (@(posedge clk) disable iff (!rst_n) (cmd[2] && !clr_wr) |=> cmd[2]);
    // R5: a clear after acknowledge empties the command word
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n) (cmd[2] && clr_wr) |=> (cmd == 3'b000));
    // R4: acknowledge only accompanies exactly one request bit
    a_r4_ack_with_op: assert property (@(posedge clk) disable iff (!rst_n) cmd[2] |-> (cmd[0] ^ cmd[1]));
endmodule

bind mbox_bridge mbox_bridge_chk #(.HA_W(HA_W), .WIN_BASE(WIN_BASE)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hst_sel  (hst_sel),
    .hst_wr   (hst_wr),
    .hst_addr (hst_addr),
    .hst_wd_lo(hst_wdata[1:0]),
    .req      (bk_req),
    .rsp      (bk_rsp_vld),
    .cmd      (cmd_view)
);

// File: tb/mbox_bridge_tb.sv
module mbox_bridge_tb_top;
    localparam int          CLK_P  = 10;
    localparam logic [31:0] E_BLD  = 32'h0003_0A01;
    localparam logic [31:0] E_FW   = 32'h0004_0506;
    localparam logic [31:0] E_MLO  = 32'h00AA_BBCC;
    localparam logic [31:0] E_MHI  = 32'h0010_DDEE;
    localparam logic [11:0] W_CMD  = 12'h400;
    localparam logic [11:0] W_ADDR = 12'h404;
    localparam logic [11:0] W_RDAT = 12'h408;
    localparam logic [11:0] W_WDAT = 12'h40C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_sel = 1'b0;
    logic        hst_wr = 1'b0;
    logic [11:0] hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        bk_stall = 1'b0;

    int          stall_mode = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          mon_go = 1'b0;
    bit          done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    mbox_bridge #(
        .BUILD_ID(E_BLD), .FW_ID(E_FW), .MAC_LO_RST(E_MLO), .MAC_HI_RST(E_MHI)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .bk_stall(bk_stall)
    );

    always #(CLK_P/2) clk = ~clk;

    initial forever begin
        @(posedge clk); #1;
        bk_stall = (stall_mode == 2) || (stall_mode == 1 && ($urandom % 4) != 0);
    end

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        if (mon_go && exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (hst_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", t, hst_rdata, e);
            end
        end
    end

    task automatic hw(input logic [11:0] a, input logic [31:0] v);
        @(posedge clk); #1;
        hst_sel = 1'b1; hst_wr = 1'b1; hst_addr = a; hst_wdata = v;
        @(posedge clk); #1;
        hst_sel = 1'b0; hst_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        hst_sel = 1'b1; hst_wr = 1'b0; hst_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag); mon_go = 1'b1;
        @(posedge clk); #1;
        hst_sel = 1'b0; mon_go = 1'b0;
    endtask

    task automatic wait_ack(input string tag);
        bit seen = 1'b0;
        for (int k = 0; k < 2000 && !seen; k++) begin
            @(posedge clk); #1;
            hst_sel = 1'b1; hst_wr = 1'b0; hst_addr = W_CMD;
            @(negedge clk);
            if (hst_rdata[2]) seen = 1'b1;
        end
        @(posedge clk); #1;
        hst_sel = 1'b0;
        n_chk++;
        if (!seen) begin
            n_fail++;
            $display("FAIL %s: actual no-ack expected ack", tag);
        end
    endtask

    task automatic do_read(input logic [31:0] ia, input logic [31:0] e, input string tag);
        hw(W_ADDR, ia);
        hw(W_CMD, 32'h1);
        wait_ack(tag);
        expect_rd(W_CMD, 32'h5, {tag, " R4 cmd=5"});
        expect_rd(W_RDAT, e, tag);
        hw(W_CMD, 32'h0);
        expect_rd(W_CMD, 32'h0, "R5 clear after read");
    endtask

    task automatic do_write(input logic [31:0] ia, input logic [31:0] v, input string tag);
        hw(W_WDAT, v);
        hw(W_ADDR, ia);
        hw(W_CMD, 32'h2);
        wait_ack(tag);
        expect_rd(W_CMD, 32'h6, {tag, " R3 cmd=6"});
        hw(W_CMD, 32'h0);
        expect_rd(W_CMD, 32'h0, "R5 clear after write");
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_rd(W_CMD,  32'h0, "R1 cmd");
        expect_rd(W_ADDR, 32'h0, "R1 addr");
        expect_rd(W_RDAT, 32'h0, "R1 rdat");
        expect_rd(W_WDAT, 32'h0, "R1 wdat");

        // R2 window decode
        hw(W_ADDR, 32'h20);
        expect_rd(W_ADDR, 32'h20, "R2 addr word");
        hw(12'h300, 32'hDEAD_BEEF);
        hw(12'h410, 32'h0000_0055);
        hw(12'h405, 32'h0000_0099);
        expect_rd(12'h300, 32'h0, "R2 outside read");
        expect_rd(12'h410, 32'h0, "R2 past window read");
        expect_rd(W_ADDR, 32'h20, "R2 outside writes no effect");

        // R10 identity and MAC contents, R4 read path
        do_read(32'h000, E_BLD, "R10 build id");
        do_read(32'h004, E_FW,  "R10 fw id");
        do_read(32'h020, E_MLO, "R10 mac low");
        do_read(32'h024, E_MHI, "R10 mac high");
        do_read(32'h200, 32'h0, "R10 unmapped");

        // R3 writes under random response latency (R9)
        stall_mode = 1;
        do_write(32'h100, 32'hCAFE_0001, "R3 scratch0");
        do_read (32'h100, 32'hCAFE_0001, "R9 scratch0 stalled");
        do_write(32'h11C, 32'h1234_5678, "R3 scratch7");
        do_read (32'h11C, 32'h1234_5678, "R10 scratch7");
        do_write(32'h024, 32'h0020_7788, "R10 mac high write");
        do_read (32'h024, 32'h0020_7788, "R10 mac high readback");
        do_write(32'h000, 32'hFFFF_FFFF, "R10 build write");
        do_read (32'h000, E_BLD, "R10 build read-only");
        stall_mode = 0;

        // R8 range/alignment
        do_write(32'h102, 32'h5555_AAAA, "R8 misaligned write");
        do_write(32'h1100, 32'h6666_BBBB, "R8 high write");
        do_read (32'h100, 32'hCAFE_0001, "R8 scratch0 untouched");
        do_read (32'h103, 32'h0, "R8 misaligned read");
        do_read (32'h1000_0100, 32'h0, "R8 high read");

        // R7 dual request bits
        hw(W_CMD, 32'h3);
        repeat (6) @(posedge clk);
        expect_rd(W_CMD, 32'h0, "R7 dual bits no-op");
        do_read(32'h004, E_FW, "R7 bridge still usable");

        // R5 host cannot set acknowledge
        hw(W_CMD, 32'h4);
        expect_rd(W_CMD, 32'h0, "R5 ack bit read-only");

        // R11 returned-data word read-only
        hw(W_RDAT, 32'h0BAD_F00D);
        expect_rd(W_RDAT, E_FW, "R11 rdat read-only");

        // R6 / R9 pending request with the register file stalled
        stall_mode = 2;
        hw(W_ADDR, 32'h11C);
        hw(W_CMD, 32'h1);
        repeat (10) @(posedge clk);
        expect_rd(W_CMD, 32'h1, "R9 no ack while stalled");
        hw(W_CMD, 32'h2);
        expect_rd(W_CMD, 32'h1, "R6 new request ignored while pending");
        hw(W_CMD, 32'h0);
        expect_rd(W_CMD, 32'h1, "R6 clear ignored while pending");
        hw(W_ADDR, 32'h100);
        stall_mode = 0;
        wait_ack("R9 ack after release");
        expect_rd(W_CMD, 32'h5, "R9 cmd=5 after release");
        expect_rd(W_RDAT, 32'h1234_5678, "R9 latched target used");
        hw(W_CMD, 32'h2);
        expect_rd(W_CMD, 32'h5, "R6 request ignored while acked");
        hw(W_CMD, 32'h0);
        expect_rd(W_CMD, 32'h0, "R5 final clear");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule